// File: doc/BRIEF.md
# Exception Entry and Vector Sequencer

This block carries out exception entry for a small 16-bit processor with 4-bit bank extensions on its program, stack and data-page pointers. A requester hands over one job at a time through a valid/ready handshake. A job is either a reset or an exception with an 8-bit vector number. With each exception job the requester also supplies the address of the next instruction and the current condition code word.

A reset job reads four words from program space, at byte addresses 0, 2, 4 and 6. These words load the bank extensions, the program counter, the stack pointer and the direct-page base.

An exception job first pushes a two-word frame onto a stack that grows downward. It then reads the handler address from the data-space vector table and loads it into the program counter. All memory traffic goes through one word-wide port. Each access is held until the memory acknowledges it, so memory latency is free to vary. The updated pointer values are always visible on the outputs.

Top module: `exc_entry_seq`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. A job is accepted on a clock edge where `req_valid` and `req_ready` are both high. `busy` rises in the next cycle and stays high until the final access of the job has been acknowledged. It falls in the cycle after that acknowledge.
- R2: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_we`, `mem_data_space` and `mem_wdata` keep their values. An access completes on a clock edge where `mem_req` and `mem_ack` are both high.
- R3: A reset job (`req_reset`=1) makes exactly four reads with `mem_data_space`=0 (program space), at byte addresses 0x0, 0x2, 0x4 and 0x6, in that order.
- R4: The reset words are loaded as follows. Word 0 sets `pk_o` from bits [3:0], `sk_o` from bits [7:4] and `zk_o` from bits [11:8]. Word 1 sets `pc_o`, word 2 sets `sp_o` and word 3 sets `iz_o`.
- R5: An exception job writes two words, both with `mem_data_space`=1. The first goes to {`sk_o`, SP−2} and the second, which is the captured condition code word, goes to {`sk_o`, SP−4}. SP here is the stack pointer before the job.
- R6: The first pushed word equals `req_next_pc` + 6, taken modulo 2^16.
- R7: After an exception job, `sp_o` equals its old value minus 4, modulo 2^16. `sk_o` is unchanged.
- R8: The last access of an exception job is a data-space read at byte address 2×vector, for any vector 0x00–0xFF. Reserved and user-defined numbers are used exactly as given, so 0xFF reads 0x1FE. The word read becomes `pc_o`, and `pk_o` is unchanged.
- R9: `ccr_o` takes `req_ccr` when an exception job is accepted. A reset job leaves `ccr_o` unchanged.
- R10: While a job is in progress, a held `req_valid` starts no access. The held job is accepted only after the current job has loaded its program counter.
- R11: After `rst_n` is released, `busy`=0, `req_ready`=1, `mem_req`=0, and all pointer outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Job offered |
| req_ready | output | 1 | Job can be accepted |
| req_reset | input | 1 | 1 = reset job, 0 = exception job |
| req_vector | input | 8 | Exception vector number |
| req_next_pc | input | 16 | Address of the next instruction |
| req_ccr | input | 16 | Condition code word to stack |
| busy | output | 1 | Job in progress |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 = write |
| mem_data_space | output | 1 | 1 = data space, 0 = program space |
| mem_addr | output | 20 | Byte address {bank, offset} |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| sp_o | output | 16 | Stack pointer |
| sk_o | output | 4 | Stack bank |
| pc_o | output | 16 | Program counter |
| pk_o | output | 4 | Program bank |
| zk_o | output | 4 | Data-page bank |
| iz_o | output | 16 | Direct-page base |
| ccr_o | output | 16 | Last captured condition code |

## Verification
The assertions assume that the memory raises `mem_ack` only while `mem_req` is high, and that `mem_rdata` is valid in the cycle of the acknowledge. The bench's memory model follows this. It drives the acknowledge only against a pending access, with a latency that cycles through 0, 1 and 2 wait cycles, and it presents read data in the same cycle as the acknowledge.

Jobs are offered only on the falling edge and are dropped after one accepting edge. Any job offered while the block is busy is kept valid until the block accepts it. No job field changes while a job is waiting.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int DW      = 16,
  parameter int EW      = 4,
  parameter int VW      = 8,
  parameter int PC_BIAS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_reset,
  input  logic [VW-1:0]    req_vector,
  input  logic [DW-1:0]    req_next_pc,
  input  logic [DW-1:0]    req_ccr,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_data_space,
  output logic [EW+DW-1:0] mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    sp_o,
  output logic [EW-1:0]    sk_o,
  output logic [DW-1:0]    pc_o,
  output logic [EW-1:0]    pk_o,
  output logic [EW-1:0]    zk_o,
  output logic [DW-1:0]    iz_o,
  output logic [DW-1:0]    ccr_o
);
  localparam int AW = EW + DW;

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_PUSH_PC, S_PUSH_CCR, S_VEC} state_t;

  state_t          state;
  logic [1:0]      init_idx;
  logic [VW-1:0]   vec_q;
  logic [DW-1:0]   frame_pc;
  logic [DW-1:0]   sp_dec;
  logic            done;

  assign sp_dec    = sp_o - DW'(2);
  assign busy      = (state != S_IDLE);
  assign req_ready = ~busy;
  assign mem_req   = busy;
  assign mem_we    = (state == S_PUSH_PC) || (state == S_PUSH_CCR);
  assign mem_data_space = (state != S_INIT);
  assign mem_wdata = (state == S_PUSH_PC) ? frame_pc : ccr_o;
  assign done      = mem_ack && ((state == S_VEC) || (state == S_INIT && init_idx == 2'd3));

  always_comb begin
    case (state)
      S_INIT:                mem_addr = AW'({init_idx, 1'b0});
      S_PUSH_PC, S_PUSH_CCR: mem_addr = {sk_o, sp_dec};
      S_VEC:                 mem_addr = AW'({vec_q, 1'b0});
      default:               mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      init_idx <= '0;
      vec_q    <= '0;
      frame_pc <= '0;
      sp_o     <= '0;
      sk_o     <= '0;
      pc_o     <= '0;
      pk_o     <= '0;
      zk_o     <= '0;
      iz_o     <= '0;
      ccr_o    <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          init_idx <= '0;
          vec_q    <= req_vector;
          frame_pc <= req_next_pc + DW'(PC_BIAS);
          if (req_reset) state <= S_INIT;
          else begin
            ccr_o <= req_ccr;
            state <= S_PUSH_PC;
          end
        end
        S_INIT: if (mem_ack) begin
          case (init_idx)
            2'd0: begin
              pk_o <= mem_rdata[EW-1:0];
              sk_o <= mem_rdata[2*EW-1:EW];
              zk_o <= mem_rdata[3*EW-1:2*EW];
            end
            2'd1: pc_o <= mem_rdata;
            2'd2: sp_o <= mem_rdata;
            default: iz_o <= mem_rdata;
          endcase
          init_idx <= init_idx + 2'd1;
          if (init_idx == 2'd3) state <= S_IDLE;
        end
        S_PUSH_PC: if (mem_ack) begin
          sp_o  <= sp_dec;
          state <= S_PUSH_CCR;
        end
        S_PUSH_CCR: if (mem_ack) begin
          sp_o  <= sp_dec;
          state <= S_VEC;
        end
        S_VEC: if (mem_ack) begin
          pc_o  <= mem_rdata;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy);                                            // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);                                                             // R1
  AST_HOLD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
      && $stable(mem_data_space) && $stable(mem_wdata));                         // R2
  AST_PROG_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_data_space |-> !mem_we && mem_addr < AW'(8));                // R3
  AST_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_data_space && mem_addr[AW-1:DW] == sk_o);          // R5
  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> sp_o == $past(sp_o) - DW'(2));              // R7
  AST_VEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_VEC && mem_ack |=> pc_o == $past(mem_rdata) && $stable(pk_o));    // R8
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_data_space && !mem_we |-> !mem_addr[0] && mem_addr <= AW'(2 * (2**VW - 1))); // R8
  AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ccr_o));                                                    // R10
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_reset = 0;
  logic [7:0] req_vector = 0;
  logic [15:0] req_next_pc = 0, req_ccr = 0;
  logic req_ready, busy, mem_req, mem_we, mem_data_space;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = 0;
  logic mem_ack = 0;
  logic [15:0] sp_o, pc_o, iz_o, ccr_o;
  logic [3:0] sk_o, pk_o, zk_o;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_reset(req_reset), .req_vector(req_vector), .req_next_pc(req_next_pc),
    .req_ccr(req_ccr), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_data_space(mem_data_space), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .sp_o(sp_o), .sk_o(sk_o),
    .pc_o(pc_o), .pk_o(pk_o), .zk_o(zk_o), .iz_o(iz_o), .ccr_o(ccr_o));

  typedef struct packed {
    logic [19:0] addr;
    logic        we;
    logic        ds;
    logic [15:0] wd;
  } acc_t;

  acc_t  exp_q[$];
  string tag_q[$];
  logic [15:0] prog_w [4];

  logic [15:0] m_sp = 0, m_pc = 0, m_iz = 0, m_ccr = 0;
  logic [3:0]  m_sk = 0, m_pk = 0, m_zk = 0;
  bit model_busy = 0, accept_flag = 0, finished = 0;
  int errors = 0, checks = 0, wait_cnt = 0, lat_ctr = 0;

  function automatic logic [15:0] dmem(input logic [19:0] a);
    return a[15:0] * 16'd37 + 16'h8001;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic [19:0] a, input logic we, input logic ds,
                      input logic [15:0] wd, input string tag);
    acc_t e;
    e.addr = a; e.we = we; e.ds = ds; e.wd = wd;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic issue(input bit rst, input logic [7:0] vec,
                       input logic [15:0] npc, input logic [15:0] ccr);
    logic [15:0] a, b;
    @(negedge clk);
    req_valid = 1; req_reset = rst; req_vector = vec; req_next_pc = npc; req_ccr = ccr;
    while (!req_ready) @(negedge clk);
    if (rst) begin
      for (int i = 0; i < 4; i++) push(20'(2 * i), 1'b0, 1'b0, 16'h0, "R3");
      m_pk = prog_w[0][3:0]; m_sk = prog_w[0][7:4]; m_zk = prog_w[0][11:8];
      m_pc = prog_w[1]; m_sp = prog_w[2]; m_iz = prog_w[3];
    end else begin
      a = m_sp - 16'd2;
      b = a - 16'd2;
      push({m_sk, a}, 1'b1, 1'b1, npc + 16'd6, "R6");
      push({m_sk, b}, 1'b1, 1'b1, ccr, "R5");
      push(20'({vec, 1'b0}), 1'b0, 1'b1, 16'h0, "R8");
      m_sp = b; m_pc = dmem(20'({vec, 1'b0})); m_ccr = ccr;
    end
    accept_flag = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic check_regs();
    chk("R7 sp", 32'(sp_o), 32'(m_sp));
    chk("R7 sk", 32'(sk_o), 32'(m_sk));
    chk("R8 pc", 32'(pc_o), 32'(m_pc));
    chk("R8 pk", 32'(pk_o), 32'(m_pk));
    chk("R4 zk", 32'(zk_o), 32'(m_zk));
    chk("R4 iz", 32'(iz_o), 32'(m_iz));
    chk("R9 ccr", 32'(ccr_o), 32'(m_ccr));
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      if (mem_ack) begin
        mem_ack = 0;
        wait_cnt = lat_ctr % 3;
        lat_ctr++;
        if (exp_q.size() == 0 && model_busy) begin
          model_busy = 0;
          check_regs();
        end
      end
      if (accept_flag) begin
        model_busy = 1;
        accept_flag = 0;
      end
      chk("R1 busy", 32'(busy), 32'(model_busy));
      chk("R1 ready", 32'(req_ready), 32'(!model_busy));
      if (mem_req) begin
        if (exp_q.size() == 0) chk("R10 unexpected access", 32'(mem_req), 32'd0);
        else begin
          chk({tag_q[0], " addr"}, 32'(mem_addr), 32'(exp_q[0].addr));
          chk("R2 we", 32'(mem_we), 32'(exp_q[0].we));
          chk({tag_q[0], " space"}, 32'(mem_data_space), 32'(exp_q[0].ds));
          if (exp_q[0].we) chk({tag_q[0], " wdata"}, 32'(mem_wdata), 32'(exp_q[0].wd));
          if (wait_cnt == 0) begin
            mem_ack = 1;
            mem_rdata = exp_q[0].ds ? dmem(exp_q[0].addr) : prog_w[exp_q[0].addr[2:1]];
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
          end else wait_cnt--;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic drain();
    while (model_busy || accept_flag || exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 busy", 32'(busy), 32'd0);
    chk("R11 ready", 32'(req_ready), 32'd1);
    chk("R11 mem_req", 32'(mem_req), 32'd0);
    chk("R11 sp", 32'(sp_o), 32'd0);
    chk("R11 pc", 32'(pc_o), 32'd0);

    prog_w[0] = 16'h0321; prog_w[1] = 16'h1000; prog_w[2] = 16'h8000; prog_w[3] = 16'h0400;
    issue(1, 8'h00, 16'h0, 16'hFFFF); drain();
    chk("R4 sk field", 32'(sk_o), 32'h2);
    chk("R9 reset keeps ccr", 32'(ccr_o), 32'h0);

    issue(0, 8'h04, 16'h1234, 16'h2345); drain();
    issue(0, 8'h17, 16'hFFFC, 16'h00A5); drain();
    chk("R6 wrap case sp", 32'(sp_o), 32'h7FF8);
    issue(0, 8'hFF, 16'h4000, 16'h1111); drain();
    issue(0, 8'h0A, 16'h5000, 16'h2222); drain();
    issue(0, 8'h00, 16'h6000, 16'h3333); drain();

    issue(0, 8'h38, 16'h7000, 16'h4444);
    issue(0, 8'h18, 16'h7100, 16'h5555); drain();
    chk("R10 both jobs done sp", 32'(sp_o), 32'h7FE4);

    prog_w[0] = 16'h0F5A; prog_w[1] = 16'h2222; prog_w[2] = 16'h0002; prog_w[3] = 16'h0800;
    issue(1, 8'h00, 16'h0, 16'h0); drain();
    issue(0, 8'h11, 16'hABCD, 16'h6666); drain();
    chk("R7 wrap sp", 32'(sp_o), 32'hFFFE);
    chk("R7 sk kept", 32'(sk_o), 32'h5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule